// File: doc/BRIEF.md
# Serial Port Interrupt Identification Logic

This block turns the pending interrupt conditions of a 16550-style serial port into one prioritized identification byte and one interrupt line. Five status conditions come in from the rest of the port: line error, receive data ready, character timeout, transmit holding register empty and modem status change. Each condition has an enable bit. The block keeps the enabled conditions and reports the most urgent of them as a code in the low nibble of the identification byte. The high bits of the byte reflect whether FIFO mode is on.

Most sources clear upstream, when the owning status register is read. The transmit-empty source is the exception and clears here. Reading the identification byte while it reports transmit-empty, or writing the transmit holding register, sets a block flag. The flag holds the transmit-empty source off until the holding register drains and reports empty again. The identification byte and the interrupt line are registered. Both reflect the inputs of the previous clock edge.

Top module: `uirq_ident`

## Requirements
- R1: `id_byte[0]` is 0 exactly when some enabled source is pending, and `irq` is 1 exactly then. When nothing is pending, `id_byte[3:0]` = 4'b0001. Both outputs follow the inputs one clock edge later.
- R2: An enabled line error has the highest priority and gives `id_byte[3:0]` = 4'b0110.
- R3: Enabled receive data ready, with no line error pending, gives `id_byte[3:0]` = 4'b0100.
- R4: An enabled character timeout, with neither of the above pending, gives `id_byte[3:0]` = 4'b1100 when `fifo_on`=1 and 4'b0100 when `fifo_on`=0. The timeout uses the receive data enable `ien_rxd`. Bit 3 is never 1 while `fifo_on`=0.
- R5: Enabled transmit-empty, with none of the above pending, gives `id_byte[3:0]` = 4'b0010.
- R6: An enabled modem status change has the lowest priority and gives `id_byte[3:0]` = 4'b0000.
- R7: A source whose enable is 0 is never reported and never raises `irq`.
- R8: A `rd_id` pulse in a cycle where `id_byte[3:0]` = 4'b0010 blocks the transmit-empty source from the next edge on. The block lasts until `st_thre` falls and rises again. A `rd_id` pulse while a different code is reported leaves the transmit-empty source pending.
- R9: A `wr_thr` pulse blocks the transmit-empty source in the same way, even if `st_thre` stays 1.
- R10: `id_byte[5:4]` is always 0. `id_byte[7:6]` is 2'b11 when `fifo_on`=1 and 2'b00 otherwise.
- R11: During reset, `id_byte` = 8'h01, `irq` = 0 and no block on the transmit-empty source is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fifo_on | input | 1 | FIFO mode enable |
| ien_line | input | 1 | Enable for line error source |
| ien_rxd | input | 1 | Enable for receive data and timeout sources |
| ien_thre | input | 1 | Enable for transmit-empty source |
| ien_mdm | input | 1 | Enable for modem status source |
| st_line | input | 1 | Line error condition (overrun, parity, framing, break) |
| st_rxd | input | 1 | Receive data ready or trigger level reached |
| st_tmo | input | 1 | Character timeout condition |
| st_thre | input | 1 | Transmit holding register empty |
| st_mdm | input | 1 | Modem status change |
| rd_id | input | 1 | One-cycle strobe: identification byte is being read |
| wr_thr | input | 1 | One-cycle strobe: transmit holding register is being written |
| id_byte | output | 8 | Interrupt identification byte |
| irq | output | 1 | Interrupt request, active high |

## Verification
Every result of this block shows up one clock edge after the inputs that cause it. This holds for the identification code, the interrupt line and the transmit-empty block set by a strobe. The bench drives its inputs on the falling edge and lets exactly one rising edge pass. It then samples on the following falling edge, where the registered outputs are stable. The strobe tests check the cycle right after the pulse, several idle cycles later, and the cycle after `st_thre` rises again, so an early or a late release of the block is caught.

// File: rtl/uirq_pkg.sv
package uirq_pkg;

    localparam int unsigned NSRC  = 5;
    localparam int unsigned SIDXW = $clog2(NSRC);
    localparam int unsigned IDW   = 8;

    // source order is the priority order: index 0 wins
    localparam logic [SIDXW-1:0] S_LINE = 3'd0;
    localparam logic [SIDXW-1:0] S_RXD  = 3'd1;
    localparam logic [SIDXW-1:0] S_TMO  = 3'd2;
    localparam logic [SIDXW-1:0] S_THRE = 3'd3;
    localparam logic [SIDXW-1:0] S_MDM  = 3'd4;

    localparam logic [3:0] NIB_IDLE = 4'b0001;
    localparam logic [3:0] NIB_THRE = 4'b0010;

    function automatic logic [3:0] src_nibble(input logic [SIDXW-1:0] idx,
                                              input logic fifo);
        logic [3:0] n;
        case (idx)
            S_LINE:  n = 4'b0110;
            S_RXD:   n = 4'b0100;
            S_TMO:   n = {fifo, 3'b100};
            S_THRE:  n = NIB_THRE;
            default: n = 4'b0000;
        endcase
        return n;
    endfunction

    typedef struct packed {
        logic [IDW-1:0] id;
        logic           irq;
    } out_st_t;

    typedef struct packed {
        logic blk;
        logic prev;
    } guard_st_t;

endpackage

// File: rtl/uirq_src_gate.sv
module uirq_src_gate #(
    parameter int unsigned N = 5
) (
    input  logic [N-1:0] raw,
    input  logic [N-1:0] en,
    output logic [N-1:0] pend
);
    for (genvar i = 0; i < N; i++) begin : g_gate
        assign pend[i] = raw[i] & en[i];
    end
endmodule

// File: rtl/uirq_prio_pick.sv
module uirq_prio_pick #(
    parameter int unsigned N  = 5,
    parameter int unsigned IW = $clog2(N)
) (
    input  logic [N-1:0]  pend,
    output logic          hit,
    output logic [IW-1:0] sel
);
    always_comb begin
        hit = 1'b0;
        sel = '0;
        for (int i = 0; i < N; i++) begin
            if (!hit && pend[i]) begin
                hit = 1'b1;
                sel = IW'(i);
            end
        end
    end
endmodule

// File: rtl/uirq_thre_guard.sv
module uirq_thre_guard (
    input  logic clk,
    input  logic rst_n,
    input  logic thr_empty,
    input  logic rd_id,
    input  logic wr_thr,
    input  logic shown_thre,
    output logic blk_d_o
);
    import uirq_pkg::*;

    guard_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.prev = thr_empty;
        if (thr_empty && !st_q.prev)
            st_d.blk = 1'b0;
        if ((rd_id && shown_thre) || wr_thr)
            st_d.blk = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign blk_d_o = st_d.blk;

    p_rd_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_id && shown_thre) |=> st_q.blk);
    p_rise_frees_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (thr_empty && !st_q.prev && !rd_id && !wr_thr) |=> !st_q.blk);
    p_wr_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_thr |=> st_q.blk);
    p_reset_free_r11: assert property (@(posedge clk)
        !rst_n |=> !st_q.blk);
endmodule

// File: rtl/uirq_ident.sv
module uirq_ident (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       fifo_on,
    input  logic       ien_line,
    input  logic       ien_rxd,
    input  logic       ien_thre,
    input  logic       ien_mdm,
    input  logic       st_line,
    input  logic       st_rxd,
    input  logic       st_tmo,
    input  logic       st_thre,
    input  logic       st_mdm,
    input  logic       rd_id,
    input  logic       wr_thr,
    output logic [7:0] id_byte,
    output logic       irq
);
    import uirq_pkg::*;

    localparam out_st_t RST_VAL = '{id: {{(IDW-4){1'b0}}, NIB_IDLE}, irq: 1'b0};

    out_st_t          o_d, o_q;
    logic             blk_d;
    logic [NSRC-1:0]  raw, en, pend;
    logic             hit;
    logic [SIDXW-1:0] sel;
    logic             shown_thre;

    assign shown_thre = (o_q.id[3:0] == NIB_THRE);

    uirq_thre_guard u_guard (
        .clk        (clk),
        .rst_n      (rst_n),
        .thr_empty  (st_thre),
        .rd_id      (rd_id),
        .wr_thr     (wr_thr),
        .shown_thre (shown_thre),
        .blk_d_o    (blk_d)
    );

    always_comb begin
        raw         = '0;
        en          = '0;
        raw[S_LINE] = st_line;           en[S_LINE] = ien_line;
        raw[S_RXD]  = st_rxd;            en[S_RXD]  = ien_rxd;
        raw[S_TMO]  = st_tmo;            en[S_TMO]  = ien_rxd;
        raw[S_THRE] = st_thre & ~blk_d;  en[S_THRE] = ien_thre;
        raw[S_MDM]  = st_mdm;            en[S_MDM]  = ien_mdm;
    end

    uirq_src_gate #(.N(NSRC)) u_gate (
        .raw  (raw),
        .en   (en),
        .pend (pend)
    );

    uirq_prio_pick #(.N(NSRC), .IW(SIDXW)) u_pick (
        .pend (pend),
        .hit  (hit),
        .sel  (sel)
    );

    always_comb begin
        o_d        = o_q;
        o_d.id     = '0;
        o_d.id[7:6] = {2{fifo_on}};
        o_d.id[3:0] = hit ? src_nibble(sel, fifo_on) : NIB_IDLE;
        o_d.irq    = |pend;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) o_q <= RST_VAL;
        else        o_q <= o_d;
    end

    assign id_byte = o_q.id;
    assign irq     = o_q.irq;

    p_irq_vs_bit0_r1: assert property (@(posedge clk) disable iff (!rst_n)
        irq == !id_byte[0]);
    p_line_wins_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_line && ien_line) |=> (id_byte[3:0] == 4'b0110));
    p_tmo_bit3_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !fifo_on |=> !id_byte[3]);
    p_masked_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!ien_line && !ien_rxd && !ien_thre && !ien_mdm) |=> !irq);
    p_upper_bits_r10: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (id_byte[5:4] == 2'b00) && (id_byte[7:6] == {2{$past(fifo_on)}}));
    p_reset_val_r11: assert property (@(posedge clk)
        !rst_n |=> (id_byte == 8'h01) && !irq);
endmodule

// File: tb/sim_uirq_ident.sv
`timescale 1ns/1ps
module sim_uirq_ident;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic fifo_on = 0, ien_line = 0, ien_rxd = 0, ien_thre = 0, ien_mdm = 0;
    logic st_line = 0, st_rxd = 0, st_tmo = 0, st_thre = 0, st_mdm = 0;
    logic rd_id = 0, wr_thr = 0;
    logic [7:0] id_byte;
    logic irq;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    uirq_ident u0 (
        .clk(clk), .rst_n(rst_n), .fifo_on(fifo_on),
        .ien_line(ien_line), .ien_rxd(ien_rxd), .ien_thre(ien_thre), .ien_mdm(ien_mdm),
        .st_line(st_line), .st_rxd(st_rxd), .st_tmo(st_tmo), .st_thre(st_thre), .st_mdm(st_mdm),
        .rd_id(rd_id), .wr_thr(wr_thr), .id_byte(id_byte), .irq(irq)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        step();
        chk("R11 id reset", id_byte, 8'h01);
        chk("R11 irq reset", {7'd0, irq}, 8'h00);
        rst_n = 1'b1;

        // exhaustive sweep, no strobes
        for (int v = 0; v < 2048; v++) begin
            logic l, r, t, e, m;
            logic [3:0] nib;
            logic [7:0] ex;
            string tg;
            {fifo_on, ien_line, ien_rxd, ien_thre, ien_mdm,
             st_line, st_rxd, st_tmo, st_thre, st_mdm} = v[9:0];
            l = ien_line & st_line;
            r = ien_rxd & st_rxd;
            t = ien_rxd & st_tmo;
            e = ien_thre & st_thre;
            m = ien_mdm & st_mdm;
            if (l)      begin nib = 4'b0110; tg = "R2"; end
            else if (r) begin nib = 4'b0100; tg = "R3"; end
            else if (t) begin nib = fifo_on ? 4'b1100 : 4'b0100; tg = "R4"; end
            else if (e) begin nib = 4'b0010; tg = "R5"; end
            else if (m) begin nib = 4'b0000; tg = "R6"; end
            else        begin nib = 4'b0001; tg = "R1 idle"; end
            step();
            chk(tg, {4'd0, id_byte[3:0]}, {4'd0, nib});
            ex = {fifo_on ? 2'b11 : 2'b00, 2'b00, 4'd0};
            chk("R10 upper bits", {id_byte[7:4], 4'd0}, ex);
            if ({ien_line, ien_rxd, ien_thre, ien_mdm} == 4'd0)
                chk("R7 masked irq", {7'd0, irq}, 8'h00);
            else
                chk("R1 irq", {7'd0, irq}, {7'd0, (l | r | t | e | m)});
        end

        // R8: read while transmit-empty reported
        {fifo_on, ien_line, ien_rxd, ien_thre, ien_mdm} = 5'b00010;
        {st_line, st_rxd, st_tmo, st_thre, st_mdm} = 5'b00010;
        step();
        chk("R5 thre shown", id_byte, 8'h02);
        rd_id = 1; step(); rd_id = 0;
        chk("R8 read clears", id_byte, 8'h01);
        chk("R8 irq low", {7'd0, irq}, 8'h00);
        step(); step(); step();
        chk("R8 stays clear", id_byte, 8'h01);
        st_thre = 0; step();
        chk("R8 still clear after fall", id_byte, 8'h01);
        st_thre = 1; step();
        chk("R8 re-raised on new empty", id_byte, 8'h02);

        // R8: read while another source shown has no effect on thre
        ien_line = 1; st_line = 1; step();
        chk("R2 over thre", id_byte, 8'h06);
        rd_id = 1; step(); rd_id = 0;
        chk("R2 still shown", id_byte, 8'h06);
        st_line = 0; step();
        chk("R8 thre kept after other read", id_byte, 8'h02);

        // R9: write blocks even with st_thre held high
        wr_thr = 1; step(); wr_thr = 0;
        chk("R9 write clears", id_byte, 8'h01);
        step(); step();
        chk("R9 stays clear", id_byte, 8'h01);
        ien_mdm = 1; st_mdm = 1; step();
        chk("R9 modem shows while thre blocked", id_byte, 8'h00);
        st_mdm = 0; st_thre = 0; step();
        st_thre = 1; step();
        chk("R9 re-raised on new empty", id_byte, 8'h02);
        chk("R9 irq back", {7'd0, irq}, 8'h01);

        // R11: reset releases block
        wr_thr = 1; step(); wr_thr = 0;
        chk("R9 blocked again", id_byte, 8'h01);
        rst_n = 0; step();
        chk("R11 id in reset", id_byte, 8'h01);
        rst_n = 1; step();
        chk("R11 block freed by reset", id_byte, 8'h02);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule